// File: doc/BRIEF.md
# Sticky Interrupt Status Slice

This block collects interrupt events into a vector of sticky status bits. Each bit can be raised by a one-cycle hardware event pulse or by software, and software can lower it. A per-bit mask selects which pending bits drive a single interrupt line toward the processor. Software reaches the block over a simple register bus: chip select, write strobe, word address, write data, byte enables, read data and an acknowledge.

Every bus access takes two cycles. The first cycle captures read data and raises the acknowledge. The second cycle, with the acknowledge high, is the only cycle in which a write changes state.

The bus sees four words:
- word 0 is the status word, write-one-to-clear;
- word 1 is a set alias, write-one-to-set, which reads back the status;
- word 2 is the mask;
- word 3 is a read-only summary of the masked status.

Top module: `intr_status_slice`

## Requirements
- R1: After the active-low asynchronous reset, the status bits, the mask, the read data, the acknowledge and the interrupt line are all 0.
- R2: The acknowledge rises one cycle after chip select is seen high while the acknowledge is low. It falls again on the following cycle, so each access lasts two cycles.
- R3: Read data is captured in the cycle the acknowledge is raised, from the word given by the word address:
  - 0 returns the status;
  - 1 returns the status;
  - 2 returns the mask;
  - 3 returns status AND mask;
  - addresses 4 to 7 return 0.
- R4: A status bit becomes 1 and stays 1 when its hardware event input is high in a cycle, with or without bus activity.
- R5: Writing to word 0 clears each status bit written with 1 and leaves bits written with 0 unchanged. Byte enable k gates write-data bits 8k+7 down to 8k.
- R6: Writing to word 1 sets each status bit written with 1 and leaves bits written with 0 unchanged. Byte enables are not used for this word.
- R7: When a set (hardware or software) and a software clear hit the same bit in the same cycle, the bit ends at 1.
- R8: A write changes state only in the acknowledge cycle, so its effect appears after the second clock edge of the access. A read changes no state.
- R9: The mask is a read/write register at word 2, written per byte under the byte enables.
- R10: The interrupt line is 1 exactly when some status bit and the same mask bit are both 1.
- R11: Writes to word 3 and to addresses 4 to 7 change neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select, held for both cycles of an access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_be | input | DATA_W/8 (4) | Byte enables |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_ack | output | 1 | Registered acknowledge |
| hw_evt | input | DATA_W (32) | One-cycle hardware event pulses, one per status bit |
| stat_o | output | DATA_W (32) | Status vector |
| irq_o | output | 1 | OR of masked status |

## Verification
Hardware pulses arrive while the bus is idle and also during the acknowledge cycle of a clearing write. Landing on a bit being cleared separates set-wins priority from clear-wins, and landing on a different bit separates merging from overwriting. Clear writes use sparse byte-enable patterns, which tell per-lane gating apart from whole-word writes. Set-alias writes use all byte enables off, which shows that the set path ignores them. The interrupt line is sampled between the two edges of a clearing access, so a write that commits in the first cycle is told apart from one that commits only in the acknowledge cycle. Writes to the summary word and to unmapped words, followed by read-backs, show that those addresses change nothing.

// File: rtl/intr_status_pkg.sv
package intr_status_pkg;

  // Word selector decoded from the low two address bits
  typedef enum logic [1:0] {
    WSEL_STAT = 2'd0,  // write-one-to-clear status
    WSEL_SETA = 2'd1,  // write-one-to-set alias, reads status
    WSEL_MASK = 2'd2,  // mask register
    WSEL_SUMM = 2'd3   // read-only masked status
  } wsel_e;

  localparam int unsigned LANE_BITS = 8;

  // Byte lane that owns a given data bit
  function automatic int unsigned lane_of(input int unsigned bit_idx);
    return bit_idx / LANE_BITS;
  endfunction

endpackage

// File: rtl/intr_bus_ctl.sv
module intr_bus_ctl
  import intr_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              ack,
  output logic              capture,
  output logic              commit,
  output wsel_e             sel,
  output logic              sel_valid
);

  logic ack_q;

  // First cycle of an access: take read data, raise ack
  assign capture = cs & ~ack_q;
  // Second cycle: the only one that may change state
  assign commit  = cs & wr & ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= capture;
  end

  assign ack       = ack_q;
  assign sel       = wsel_e'(addr[1:0]);
  assign sel_valid = (addr[ADDR_W-1:2] == '0);

endmodule

// File: rtl/intr_stat_bits.sv
module intr_stat_bits #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] stat
);

  // Set has priority over clear
  function automatic logic next_bit(input logic cur, input logic s, input logic c);
    return s | (cur & ~c);
  endfunction

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= next_bit(stat[i], set_vec[i], clr_vec[i]);
    end
  end

endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg
  import intr_status_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask[k*LANE_BITS +: LANE_BITS] <= '0;
      else if (lane_we[k]) mask[k*LANE_BITS +: LANE_BITS] <= wdata[k*LANE_BITS +: LANE_BITS];
    end
  end

endmodule

// File: rtl/intr_status_slice.sv
module intr_status_slice
  import intr_status_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned LANES = DATA_W / LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic [DATA_W-1:0] hw_evt,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);

  // Spread byte enables over their data bits
  function automatic logic [DATA_W-1:0] expand_lanes(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = be[lane_of(i)];
    return r;
  endfunction

  logic              capture, commit, sel_valid;
  wsel_e             sel;
  logic              hit_stat, hit_seta, hit_mask;
  logic [DATA_W-1:0] clr_vec, sw_set_vec, set_vec;
  logic [LANES-1:0]  mask_we;
  logic [DATA_W-1:0] stat, mask, masked, rd_mux, rdata_q;

  intr_bus_ctl #(.ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (bus_cs),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .ack       (bus_ack),
    .capture   (capture),
    .commit    (commit),
    .sel       (sel),
    .sel_valid (sel_valid)
  );

  assign hit_stat   = commit & sel_valid & (sel == WSEL_STAT);
  assign hit_seta   = commit & sel_valid & (sel == WSEL_SETA);
  assign hit_mask   = commit & sel_valid & (sel == WSEL_MASK);

  assign clr_vec    = hit_stat ? (bus_wdata & expand_lanes(bus_be)) : '0;
  assign sw_set_vec = hit_seta ? bus_wdata : '0;
  assign set_vec    = hw_evt | sw_set_vec;
  assign mask_we    = hit_mask ? bus_be : '0;

  intr_stat_bits #(.DATA_W(DATA_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat    (stat)
  );

  intr_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_we (mask_we),
    .wdata   (bus_wdata),
    .mask    (mask)
  );

  assign masked = stat & mask;

  always_comb begin
    rd_mux = '0;
    if (sel_valid) begin
      unique case (sel)
        WSEL_STAT, WSEL_SETA: rd_mux = stat;
        WSEL_MASK:            rd_mux = mask;
        WSEL_SUMM:            rd_mux = masked;
        default:              rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign stat_o    = stat;
  assign irq_o     = |masked;

endmodule

// File: rtl/intr_status_chk.sv
module intr_status_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              ack,
  input logic [DATA_W-1:0] hw_evt,
  input logic [DATA_W-1:0] set_vec,
  input logic [DATA_W-1:0] clr_vec,
  input logic [DATA_W-1:0] stat,
  input logic [DATA_W-1:0] mask,
  input logic              irq
);

  p_ack_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !ack) |=> ack);

  p_ack_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_hw_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((stat & $past(hw_evt)) == $past(hw_evt)));

  p_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((stat & $past(clr_vec) & ~$past(set_vec)) == '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((stat & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  p_no_clear_off_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (clr_vec == '0));

  p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && hw_evt == '0) |=> $stable(stat));

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(mask));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & mask) == '0) |-> !irq);

endmodule

bind intr_status_slice intr_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs      (bus_cs),
  .ack     (bus_ack),
  .hw_evt  (hw_evt),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .stat    (stat),
  .mask    (mask),
  .irq     (irq_o)
);

// File: tb/sim_intr_status_slice.sv
`timescale 1ns/1ps
module sim_intr_status_slice;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [31:0] hw_evt = '0;
  logic [31:0] stat_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fails = 0;
  int cycles = 0;
  logic done = 1'b0;

  // Values seen inside the most recent access
  logic        ack_mid, ack_end, irq_mid, irq_end;
  logic [31:0] rd;

  always #10 clk = ~clk;

  intr_status_slice u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .hw_evt(hw_evt),
    .stat_o(stat_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000 && !done) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Two-cycle access; hw_mid is driven during the ack cycle
  task automatic access(input logic w, input logic [2:0] a, input logic [31:0] d,
                        input logic [3:0] b, input logic [31:0] hw_mid);
    @(negedge clk);
    bus_cs = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d; bus_be = b;
    @(negedge clk);
    ack_mid = bus_ack; irq_mid = irq_o; rd = bus_rdata; hw_evt = hw_mid;
    @(negedge clk);
    ack_end = bus_ack; irq_end = irq_o;
    hw_evt = '0; bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pulse_hw(input logic [31:0] v);
    @(negedge clk); hw_evt = v;
    @(negedge clk); hw_evt = '0;
  endtask

  task automatic t_reset;
    check("R1 stat", stat_o, 32'h0);
    check("R1 ack", {31'h0, bus_ack}, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    access(1'b0, 3'd2, 32'h0, 4'h0, 32'h0);
    check("R1 mask", rd, 32'h0);
  endtask

  task automatic t_handshake;
    access(1'b0, 3'd0, 32'h0, 4'h0, 32'h0);
    check("R2 ack rise", {31'h0, ack_mid}, 32'h1);
    check("R2 ack fall", {31'h0, ack_end}, 32'h0);
  endtask

  task automatic t_hw_set;
    pulse_hw(32'h0000_8001);
    check("R4 stat after pulse", stat_o, 32'h0000_8001);
    repeat (3) @(negedge clk);
    check("R4 sticky", stat_o, 32'h0000_8001);
    access(1'b0, 3'd0, 32'h0, 4'h0, 32'h0040_0000);
    check("R3 read status", rd, 32'h0000_8001);
    check("R4 set during read", stat_o, 32'h0040_8001);
    access(1'b0, 3'd1, 32'hFFFF_FFFF, 4'hF, 32'h0);
    check("R3 alias reads status", rd, 32'h0040_8001);
    check("R8 read leaves state", stat_o, 32'h0040_8001);
  endtask

  task automatic t_w1c;
    pulse_hw(32'hFFFF_FFFF);
    access(1'b1, 3'd0, 32'hFFFF_FFFF, 4'b0101, 32'h0);
    check("R5 lane gating", stat_o, 32'hFF00_FF00);
    access(1'b1, 3'd0, 32'h0100_0000, 4'hF, 32'h0);
    check("R5 single bit", stat_o, 32'hFE00_FF00);
    access(1'b1, 3'd0, 32'h0, 4'hF, 32'h0);
    check("R5 zeros keep", stat_o, 32'hFE00_FF00);
  endtask

  task automatic t_w1s;
    access(1'b1, 3'd1, 32'h0000_00F0, 4'h0, 32'h0);
    check("R6 set ignores be", stat_o, 32'hFE00_FFF0);
    access(1'b1, 3'd1, 32'h0, 4'hF, 32'h0);
    check("R6 zeros keep", stat_o, 32'hFE00_FFF0);
  endtask

  task automatic t_set_wins;
    access(1'b1, 3'd0, 32'hFFFF_FFFF, 4'hF, 32'h0);
    check("R5 clear all", stat_o, 32'h0);
    access(1'b1, 3'd1, 32'h0000_0004, 4'hF, 32'h0);
    access(1'b1, 3'd0, 32'h0000_000C, 4'hF, 32'h0000_0008);
    check("R7 set beats clear", stat_o, 32'h0000_0008);
    access(1'b1, 3'd0, 32'h0000_0008, 4'hF, 32'h0001_0008);
    check("R7 held bit and merge", stat_o, 32'h0001_0008);
  endtask

  task automatic t_commit_timing;
    access(1'b1, 3'd0, 32'hFFFF_FFFF, 4'hF, 32'h0);
    access(1'b1, 3'd2, 32'h0000_0001, 4'h1, 32'h0);
    pulse_hw(32'h0000_0001);
    check("R10 irq on", {31'h0, irq_o}, 32'h1);
    access(1'b1, 3'd0, 32'h0000_0001, 4'h1, 32'h0);
    check("R8 no effect before ack cycle", {31'h0, irq_mid}, 32'h1);
    check("R8 effect after ack cycle", {31'h0, irq_end}, 32'h0);
  endtask

  task automatic t_mask;
    access(1'b1, 3'd2, 32'h1234_5678, 4'hF, 32'h0);
    access(1'b1, 3'd2, 32'hFFFF_FFFF, 4'b0010, 32'h0);
    access(1'b0, 3'd2, 32'h0, 4'h0, 32'h0);
    check("R9 mask per byte", rd, 32'h1234_FF78);
    access(1'b1, 3'd1, 32'h0000_0100, 4'hF, 32'h0);
    check("R10 masked bit irq", {31'h0, irq_o}, 32'h1);
    access(1'b0, 3'd3, 32'h0, 4'h0, 32'h0);
    check("R3 summary", rd, 32'h0000_0100);
    access(1'b1, 3'd2, 32'h0, 4'hF, 32'h0);
    check("R10 masked off", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_ignored;
    access(1'b1, 3'd3, 32'hFFFF_FFFF, 4'hF, 32'h0);
    check("R11 summary write stat", stat_o, 32'h0000_0100);
    access(1'b1, 3'd5, 32'hFFFF_FFFF, 4'hF, 32'h0);
    check("R11 unmapped write stat", stat_o, 32'h0000_0100);
    access(1'b0, 3'd2, 32'h0, 4'h0, 32'h0);
    check("R11 mask untouched", rd, 32'h0);
    access(1'b0, 3'd6, 32'h0, 4'h0, 32'h0);
    check("R3 unmapped reads zero", rd, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_hw_set();
    t_w1c();
    t_w1s();
    t_set_wins();
    t_commit_timing();
    t_mask();
    t_ignored();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule